// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Combiner

This block takes ten interrupt request lines and merges them into one registered interrupt line for a processor core. Each line sets a sticky flag on its rising edge. A flag reaches the processor only when its own enable bit is set and the global enable is set. Three core sources need only those two enables. Seven peripheral sources also need a group enable for the peripheral set.

Software reaches the block through a small register port with a 2-bit address. One control register holds the two group enables, the three core enables and the three core flags. Two further registers hold the seven peripheral flags and the seven peripheral enables. When the processor takes the interrupt, an acknowledge strobe clears the global enable so the handler is not entered again. A return strobe sets the global enable again. The handler may also write the global enable back to 1 itself, so that a second, lower-priority source can interrupt while the first is still being served.

Top module: `irq_merge_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every enable, every flag and `cpu_irq`.
- R2: A 0-to-1 change on `src_req[i]` sets that source's flag at the next clock edge. A request held high does not set the flag again after software has cleared it. Line mapping: `src_req[0]` is port change, `[1]` is the external pin, `[2]` is timer-0, and `[3]`..`[9]` are peripheral flags 0..6 (timer-1 overflow, timer-2 match, capture/compare, comparator, serial transmit, serial receive, EEPROM write done).
- R3: Flags are sticky and are cleared only by a software write of 0. If a rising request arrives in the same cycle as a write of 0, the flag stays set.
- R4: Control register (address 0) layout: bit7 is the global enable, bit6 the peripheral group enable, bits 5/4/3 the timer-0, external-pin and port-change enables, and bits 2/1/0 the timer-0, external-pin and port-change flags.
- R5: Address 1 holds the peripheral flags and address 2 holds the peripheral enables, in bits 6..0 in the order of R2. Bit 7 of both reads 0. Address 3 reads 0 and ignores writes.
- R6: `cpu_irq` goes high one clock after a core flag, its enable and the global enable are all set.
- R7: A peripheral flag raises `cpu_irq` only when its enable, the peripheral group enable and the global enable are all set.
- R8: A source whose enable is clear still records its flag but does not raise `cpu_irq`.
- R9: `irq_ack` clears the global enable. `irq_ret` sets it. If both arrive together, `irq_ack` wins. Both take priority over a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 10 | Interrupt request lines, mapped as in R2 |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq_ack | input | 1 | Interrupt taken by the processor |
| irq_ret | input | 1 | Return from the handler |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
The bench drives a rising request in the same cycle as a software clear. A design that lets the clear win would lose that interrupt. It holds a request high across a clear. A level-triggered design would set the flag again at once and trap the handler in a loop. It raises a peripheral flag while the group enable is clear, and a flag whose own enable is clear. A design that skipped either gate would interrupt when it should not. It also drives acknowledge and return in the same cycle. A design with the wrong priority would leave the global enable set when the handler is entered.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int CORE_N   = 3;
    localparam int PERIPH_N = 7;
    localparam int SRC_N    = CORE_N + PERIPH_N;
    localparam int REG_W    = 8;
    localparam int ADDR_W   = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_PFLAG = 2'd1,
        SEL_PEN   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    // Packed order matches the control register bit layout (bit7 first).
    typedef struct packed {
        logic              gie;
        logic              peie;
        logic [CORE_N-1:0] core_en;
        logic [CORE_N-1:0] core_flag;
    } ctrl_t;

    typedef struct packed {
        logic ctrl;
        logic pflag;
        logic pen;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(input logic wr, input logic [ADDR_W-1:0] addr);
        wr_dec_t d;
        d.ctrl  = wr && (addr == SEL_CTRL);
        d.pflag = wr && (addr == SEL_PFLAG);
        d.pen   = wr && (addr == SEL_PEN);
        return d;
    endfunction

    function automatic logic next_gie(input logic cur, input logic ack, input logic ret,
                                      input logic wr, input logic wval);
        if (ack)      return 1'b0;
        else if (ret) return 1'b1;
        else if (wr)  return wval;
        else          return cur;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         wr_en,
    input  logic [N-1:0] wr_val,
    output logic [N-1:0] flags
);
    logic [N-1:0] req_q;
    logic [N-1:0] rise;

    assign rise = req & ~req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            flags <= '0;
        end else begin
            req_q <= req;
            flags <= (wr_en ? wr_val : flags) | rise;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R2: a rising request sets the flag on the next edge
        p_rise_sets_r2: assert property (@(posedge clk) disable iff (rst)
            (req[i] && !req_q[i]) |=> flags[i]);
        // R3: a set flag survives unless software writes 0
        p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && !(wr_en && !wr_val[i])) |=> flags[i]);
        // R3: a write of 0 with no rising request clears the flag
        p_clear_r3: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !wr_val[i] && !(req[i] && !req_q[i])) |=> !flags[i]);
    end
endmodule

// File: rtl/irq_mask_tree.sv
module irq_mask_tree #(
    parameter int NC = 3,
    parameter int NP = 7
) (
    input  logic          gie,
    input  logic          peie,
    input  logic [NC-1:0] core_en,
    input  logic [NC-1:0] core_flag,
    input  logic [NP-1:0] per_en,
    input  logic [NP-1:0] per_flag,
    output logic          want
);
    logic [NC-1:0] core_hit;
    logic [NP-1:0] per_hit;

    for (genvar i = 0; i < NC; i++) begin : g_core
        assign core_hit[i] = core_en[i] & core_flag[i];
    end
    for (genvar j = 0; j < NP; j++) begin : g_per
        assign per_hit[j] = per_en[j] & per_flag[j];
    end

    assign want = gie & ((|core_hit) | (peie & (|per_hit)));
endmodule

// File: rtl/irq_merge_ctrl.sv
module irq_merge_ctrl
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [SRC_N-1:0]    src_req,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                irq_ack,
    input  logic                irq_ret,
    output logic                cpu_irq
);
    localparam int PAD_W = REG_W - PERIPH_N;

    wr_dec_t             wdec;
    ctrl_t               wval;
    ctrl_t               ctrl_view;
    logic                gie_q;
    logic                peie_q;
    logic [CORE_N-1:0]   core_en_q;
    logic [CORE_N-1:0]   core_flags;
    logic [PERIPH_N-1:0] per_en_q;
    logic [PERIPH_N-1:0] per_flags;
    logic                want;

    assign wdec = decode_write(reg_wr, reg_addr);
    assign wval = ctrl_t'(reg_wdata);

    irq_flag_bank #(.N(CORE_N)) u_core_flags (
        .clk    (clk),
        .rst    (rst),
        .req    (src_req[CORE_N-1:0]),
        .wr_en  (wdec.ctrl),
        .wr_val (wval.core_flag),
        .flags  (core_flags)
    );

    irq_flag_bank #(.N(PERIPH_N)) u_per_flags (
        .clk    (clk),
        .rst    (rst),
        .req    (src_req[SRC_N-1:CORE_N]),
        .wr_en  (wdec.pflag),
        .wr_val (reg_wdata[PERIPH_N-1:0]),
        .flags  (per_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q     <= 1'b0;
            peie_q    <= 1'b0;
            core_en_q <= '0;
            per_en_q  <= '0;
        end else begin
            gie_q <= next_gie(gie_q, irq_ack, irq_ret, wdec.ctrl, wval.gie);
            if (wdec.ctrl) begin
                peie_q    <= wval.peie;
                core_en_q <= wval.core_en;
            end
            if (wdec.pen) per_en_q <= reg_wdata[PERIPH_N-1:0];
        end
    end

    irq_mask_tree #(.NC(CORE_N), .NP(PERIPH_N)) u_tree (
        .gie       (gie_q),
        .peie      (peie_q),
        .core_en   (core_en_q),
        .core_flag (core_flags),
        .per_en    (per_en_q),
        .per_flag  (per_flags),
        .want      (want)
    );

    always_ff @(posedge clk) begin
        if (rst) cpu_irq <= 1'b0;
        else     cpu_irq <= want;
    end

    always_comb begin
        ctrl_view.gie       = gie_q;
        ctrl_view.peie      = peie_q;
        ctrl_view.core_en   = core_en_q;
        ctrl_view.core_flag = core_flags;
        unique case (reg_sel_e'(reg_addr))
            SEL_CTRL:  reg_rdata = ctrl_view;
            SEL_PFLAG: reg_rdata = {{PAD_W{1'b0}}, per_flags};
            SEL_PEN:   reg_rdata = {{PAD_W{1'b0}}, per_en_q};
            default:   reg_rdata = '0;
        endcase
    end

    // R1: reset leaves no request and no global enable
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!cpu_irq && !gie_q));
    // R9: acknowledge clears the global enable
    p_ack_gie_r9: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !gie_q);
    // R9: return without acknowledge sets it
    p_ret_gie_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_ret && !irq_ack) |=> gie_q);
    // R6: no request unless the global enable was set
    p_irq_gated_r6: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> $past(gie_q));
    // R7: with the group enable clear, only core sources may interrupt
    p_periph_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (!peie_q && !(|(core_en_q & core_flags))) |=> !cpu_irq);
endmodule

// File: tb/irq_merge_ctrl_bench.sv
module irq_merge_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] src_req = '0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_ack = 1'b0;
    logic       irq_ret = 1'b0;
    logic       cpu_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    irq_merge_ctrl u_irq_merge_ctrl (
        .clk(clk), .rst(rst), .src_req(src_req), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .cpu_irq(cpu_irq)
    );

    // Monitor: compares the oldest expected item at each falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            act = it.is_irq ? {7'd0, cpu_irq} : reg_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic pulse_req(input int idx);
        src_req[idx] = 1'b1;
        tick();
        src_req[idx] = 1'b0;
    endtask

    task automatic exp_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        tick();
    endtask

    task automatic exp_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {7'd0, e}; it.tag = tag;
        sb.push_back(it);
        tick();
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1: reset state
        exp_rd(2'd0, 8'h00, "R1 ctrl");
        exp_rd(2'd1, 8'h00, "R1 pflag");
        exp_rd(2'd2, 8'h00, "R1 pen");
        exp_irq(1'b0, "R1 irq");

        // R2/R8: timer-0 flag sets with no enables, no interrupt
        pulse_req(2);
        exp_rd(2'd0, 8'h04, "R2 timer0 flag");
        exp_irq(1'b0, "R8 disabled no irq");

        // R2: held request, cleared by software, does not re-set
        src_req[1] = 1'b1;
        tick(); tick();
        exp_rd(2'd0, 8'h06, "R2 ext flag");
        wr(2'd0, 8'h00);
        exp_rd(2'd0, 8'h00, "R2 held level no reset");
        src_req[1] = 1'b0;

        // R3: rise in the same cycle as a clear write keeps the flag
        src_req[0] = 1'b1;
        wr(2'd0, 8'h00);
        src_req[0] = 1'b0;
        exp_rd(2'd0, 8'h01, "R3 set wins over clear");
        wr(2'd0, 8'h00);
        exp_rd(2'd0, 8'h00, "R3 cleared by write 0");

        // R4/R6: global + timer-0 enable
        wr(2'd0, 8'hA0);
        pulse_req(2);
        tick();
        exp_irq(1'b1, "R6 core irq");
        exp_rd(2'd0, 8'hA4, "R4 ctrl layout");

        // R9: acknowledge clears the global enable
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        exp_rd(2'd0, 8'h24, "R9 ack clears gie");
        exp_irq(1'b0, "R9 irq drops after ack");
        irq_ret = 1'b1; tick(); irq_ret = 1'b0;
        exp_rd(2'd0, 8'hA4, "R9 ret sets gie");
        exp_irq(1'b1, "R9 irq back after ret");
        wr(2'd0, 8'hA0);
        tick();
        exp_irq(1'b0, "R3 irq ends after clear");
        irq_ack = 1'b1; irq_ret = 1'b1; tick();
        irq_ack = 1'b0; irq_ret = 1'b0;
        exp_rd(2'd0, 8'h20, "R9 ack wins over ret");

        // R7: peripheral group gating
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h80);
        pulse_req(3);
        exp_rd(2'd1, 8'h01, "R5 timer1 flag bit0");
        exp_irq(1'b0, "R7 no irq without group enable");
        wr(2'd0, 8'hC0);
        tick();
        exp_irq(1'b1, "R7 irq with group enable");
        wr(2'd2, 8'h00);
        tick();
        exp_irq(1'b0, "R8 peripheral masked");
        pulse_req(9);
        exp_rd(2'd1, 8'h41, "R8 masked flag still sets");
        wr(2'd2, 8'hFF);
        exp_rd(2'd2, 8'h7F, "R5 pen bit7 reads 0");
        exp_irq(1'b1, "R7 irq after enabling");
        wr(2'd1, 8'h00);
        tick();
        exp_irq(1'b0, "R3 periph flags cleared irq");
        exp_rd(2'd1, 8'h00, "R3 periph flags cleared");

        // R5: unused address
        wr(2'd3, 8'hFF);
        exp_rd(2'd3, 8'h00, "R5 addr3 reads 0");
        exp_rd(2'd0, 8'hC0, "R5 addr3 write ignored");

        tick(); tick();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule